// File: doc/BRIEF.md
# Precise Exception Steering Unit

This unit decides, for a five-stage in-order pipeline, when fetch leaves the normal program flow for an exception handler. It watches two fault flags. One is an illegal-opcode flag from the decode stage. The other is an arithmetic-overflow flag from the execute stage. Each flag comes with the program counter of the instruction in that stage. When a fault is accepted, the unit does four things in the next cycle:

- it flushes the fetch, decode and execute stages;
- it blocks the register write of an overflowing instruction;
- it steers fetch to a handler address;
- it records the resume address and the reason for the fault.

Older instructions further down the pipe drain normally. When both stages report a fault in the same cycle, the execute-stage fault wins, because that instruction is older. The younger decode fault is dropped with the flush.

A mode pin selects the handler address. In fixed mode every fault goes to one shared entry point. In vectored mode each cause has its own slot in a table of evenly spaced entries. The recorded resume address is the faulting instruction's address plus one instruction width. The handler must subtract that width before it returns to re-execute the instruction.

Top module: `trap_steer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `epc_q` = 0, `cause_q` = 0, and `redirect`, `wb_kill` and all three flush outputs low.
- R2: A lone `dec_illegal` in cycle T (no strobe active) produces, in cycle T+1, `redirect` = 1, `cause_q` = 0 and `epc_q` = `dec_pc` + 4, with `wb_kill` = 0.
- R3: A lone `ex_ovf` in cycle T (no strobe active) produces, in cycle T+1, `redirect` = 1, `cause_q` = 1, `epc_q` = `ex_pc` + 4 and `wb_kill` = 1.
- R4: When `ex_ovf` and `dec_illegal` are both high in the same accepted cycle, the result is the R3 result, taken from `ex_pc`.
- R5: If `vec_mode` = 0 in the accepted cycle, `redirect_pc` = 0x80000180 during the strobe.
- R6: If `vec_mode` = 1 in the accepted cycle, `redirect_pc` = 0xC0000000 + 0x20 × cause during the strobe. That is 0xC0000000 for an illegal opcode and 0xC0000020 for an overflow.
- R7: `redirect`, `flush_if`, `flush_id` and `flush_ex` are high together for exactly one cycle per accepted fault.
- R8: Fault flags raised while the strobe is high are ignored. The next cycle has `redirect` = 0 and unchanged `epc_q` and `cause_q`.
- R9: With no fault flag raised, `epc_q` and `cause_q` keep their last values, and `redirect` stays low.
- R10: The resume address wraps modulo 2^32, so a fault at 0xFFFFFFFC records 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_mode | input | 1 | 1 = per-cause vector table, 0 = single handler entry |
| dec_illegal | input | 1 | Illegal opcode detected in decode |
| dec_pc | input | 32 | Address of the decode-stage instruction |
| ex_ovf | input | 1 | Arithmetic overflow detected in execute |
| ex_pc | input | 32 | Address of the execute-stage instruction |
| flush_if | output | 1 | Discard the fetch-stage instruction |
| flush_id | output | 1 | Discard the decode-stage instruction |
| flush_ex | output | 1 | Discard the execute-stage instruction |
| wb_kill | output | 1 | Block the register write of the overflowing instruction |
| redirect | output | 1 | One-cycle strobe to load `redirect_pc` into fetch |
| redirect_pc | output | 32 | Handler entry address |
| epc_q | output | 32 | Recorded resume address (fault address + 4) |
| cause_q | output | 1 | Recorded reason: 0 illegal opcode, 1 overflow |

## Verification
Every result comes from one register stage. Flags and program counters presented in cycle T show up on `redirect`, the flushes, `wb_kill`, `redirect_pc`, `epc_q` and `cause_q` in cycle T+1, and the strobe has dropped again by T+2. The bench drives inputs on the falling edge and then samples on the falling edge one cycle later. That second falling edge is also where it drives the interfering flags for the ignore case. The next falling edge then checks that the strobe fell and the recorded state held. Expected addresses come from adding in the bench, separate from the design's functions.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] addr_t;

  typedef enum logic {
    CAUSE_ILLEGAL = 1'b0,
    CAUSE_OVF     = 1'b1
  } cause_e;

  // address at which the faulting instruction is re-executed, plus one width
  function automatic addr_t resume_addr(addr_t pc, addr_t step);
    return pc + step;
  endfunction

  // slot address inside an evenly spaced handler table
  function automatic addr_t slot_addr(addr_t base, cause_e c, int unsigned stride_log2);
    addr_t idx;
    idx = addr_t'(c);
    return base + (idx << stride_log2);
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic   dec_flag,
  input  logic   ex_flag,
  input  logic   busy,
  input  addr_t  dec_pc,
  input  addr_t  ex_pc,
  output logic   take,
  output cause_e sel_cause,
  output addr_t  sel_pc
);
  // oldest instruction first: execute outranks decode
  always_comb begin
    take      = (dec_flag | ex_flag) & ~busy;
    sel_cause = ex_flag ? CAUSE_OVF : CAUSE_ILLEGAL;
    sel_pc    = ex_flag ? ex_pc : dec_pc;
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter addr_t       FIXED_ENTRY = 32'h8000_0180,
  parameter addr_t       TABLE_BASE  = 32'hC000_0000,
  parameter int unsigned SLOT_LOG2   = 5
) (
  input  logic   per_cause,
  input  cause_e cause,
  output addr_t  target
);
  always_comb begin
    target = per_cause ? slot_addr(TABLE_BASE, cause, SLOT_LOG2) : FIXED_ENTRY;
  end
endmodule

// File: rtl/trap_steer.sv
module trap_steer
  import trap_pkg::*;
#(
  parameter addr_t       INSN_BYTES  = 32'd4,
  parameter addr_t       FIXED_ENTRY = 32'h8000_0180,
  parameter addr_t       TABLE_BASE  = 32'hC000_0000,
  parameter int unsigned SLOT_LOG2   = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        vec_mode,
  input  logic        dec_illegal,
  input  logic [31:0] dec_pc,
  input  logic        ex_ovf,
  input  logic [31:0] ex_pc,
  output logic        flush_if,
  output logic        flush_id,
  output logic        flush_ex,
  output logic        wb_kill,
  output logic        redirect,
  output logic [31:0] redirect_pc,
  output logic [31:0] epc_q,
  output logic        cause_q
);
  // named internal events
  logic   accept_ev;
  cause_e win_cause;
  addr_t  win_pc;
  addr_t  entry_addr;

  logic   strobe_q;
  cause_e cause_r;
  addr_t  epc_r;
  addr_t  target_r;

  trap_arbiter u_arb (
    .dec_flag (dec_illegal),
    .ex_flag  (ex_ovf),
    .busy     (strobe_q),
    .dec_pc   (dec_pc),
    .ex_pc    (ex_pc),
    .take     (accept_ev),
    .sel_cause(win_cause),
    .sel_pc   (win_pc)
  );

  trap_vector #(
    .FIXED_ENTRY(FIXED_ENTRY),
    .TABLE_BASE (TABLE_BASE),
    .SLOT_LOG2  (SLOT_LOG2)
  ) u_vec (
    .per_cause(vec_mode),
    .cause    (win_cause),
    .target   (entry_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      cause_r  <= CAUSE_ILLEGAL;
      epc_r    <= '0;
      target_r <= '0;
    end else begin
      strobe_q <= accept_ev;
      if (accept_ev) begin
        cause_r  <= win_cause;
        epc_r    <= resume_addr(win_pc, INSN_BYTES);
        target_r <= entry_addr;
      end
    end
  end

  assign redirect    = strobe_q;
  assign flush_if    = strobe_q;
  assign flush_id    = strobe_q;
  assign flush_ex    = strobe_q;
  assign wb_kill     = strobe_q & (cause_r == CAUSE_OVF);
  assign redirect_pc = target_r;
  assign epc_q       = epc_r;
  assign cause_q     = cause_r;

  // R7: strobe never lasts two cycles
  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect);

  // R8: flags during the strobe leave recorded state alone
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
    redirect |=> ($stable(epc_q) && $stable(cause_q)));

  // R9: recorded state only moves together with a strobe
  assert_hold_state_R9: assert property (@(posedge clk) disable iff (rst)
    !redirect |-> ($stable(epc_q) && $stable(cause_q)));

  // R4 / R3: an execute fault always owns the strobe and kills writeback
  assert_oldest_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (redirect && $past(ex_ovf)) |-> (cause_q && wb_kill && epc_q == $past(ex_pc) + INSN_BYTES));

  // R2: decode-only fault records the decode address
  assert_decode_epc_R2: assert property (@(posedge clk) disable iff (rst)
    (redirect && !$past(ex_ovf)) |-> (!cause_q && !wb_kill && epc_q == $past(dec_pc) + INSN_BYTES));

  // R5: fixed mode sampled in the accepting cycle
  assert_fixed_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (redirect && !$past(vec_mode)) |-> (redirect_pc == FIXED_ENTRY));
endmodule

// File: tb/sim_trap_steer.sv
`timescale 1ns/1ps
module sim_trap_steer;
  logic        clk = 1'b0;
  logic        rst;
  logic        vec_mode, dec_illegal, ex_ovf;
  logic [31:0] dec_pc, ex_pc;
  logic        flush_if, flush_id, flush_ex, wb_kill, redirect, cause_q;
  logic [31:0] redirect_pc, epc_q;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_epc;
  logic        exp_cause;

  always #2.5 clk = ~clk;

  trap_steer u0 (
    .clk(clk), .rst(rst), .vec_mode(vec_mode),
    .dec_illegal(dec_illegal), .dec_pc(dec_pc),
    .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex),
    .wb_kill(wb_kill), .redirect(redirect), .redirect_pc(redirect_pc),
    .epc_q(epc_q), .cause_q(cause_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dec_illegal = 1'b0; ex_ovf = 1'b0;
  endtask

  // one stimulus cycle, results checked one cycle later, then the ignore window
  task automatic run_case(input logic m, input logic d, input logic e,
                          input logic [31:0] dpc, input logic [31:0] epc_in);
    logic fire;
    logic [31:0] exp_tgt;
    @(negedge clk);
    vec_mode = m; dec_illegal = d; ex_ovf = e; dec_pc = dpc; ex_pc = epc_in;
    fire = d | e;
    if (fire) begin
      exp_cause = e;
      exp_epc   = (e ? epc_in : dpc) + 32'd4;
    end
    exp_tgt = m ? (32'hC000_0000 + {31'd0, exp_cause} * 32'h20) : 32'h8000_0180;
    @(negedge clk);
    // R8 stimulus: both flags during the strobe, plus a mode flip
    dec_illegal = 1'b1; ex_ovf = 1'b1; dec_pc = 32'h0000_1230; ex_pc = 32'h0000_4560;
    vec_mode = ~m;
    if (fire) begin
      chk(e ? "R3/R4 redirect" : "R2 redirect", {31'd0, redirect}, 32'd1);
      chk("R7 flushes", {29'd0, flush_if, flush_id, flush_ex}, 32'd7);
      chk(e ? "R3/R4 epc" : "R2 epc", epc_q, exp_epc);
      chk(e ? "R3/R4 cause" : "R2 cause", {31'd0, cause_q}, {31'd0, exp_cause});
      chk(e ? "R3 wb_kill" : "R2 wb_kill", {31'd0, wb_kill}, {31'd0, e});
      chk(m ? "R6 vector" : "R5 fixed", redirect_pc, exp_tgt);
    end else begin
      idle_inputs();
      chk("R9 no redirect", {31'd0, redirect}, 32'd0);
      chk("R9 epc hold", epc_q, exp_epc);
      chk("R9 cause hold", {31'd0, cause_q}, {31'd0, exp_cause});
    end
    @(negedge clk);
    idle_inputs();
    if (fire) begin
      chk("R7/R8 strobe dropped", {31'd0, redirect}, 32'd0);
      chk("R7 flush dropped", {29'd0, flush_if, flush_id, flush_ex}, 32'd0);
      chk("R8 epc unchanged", epc_q, exp_epc);
      chk("R8 cause unchanged", {31'd0, cause_q}, {31'd0, exp_cause});
    end
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pcs [4];
    pcs[0] = 32'h0000_004C; pcs[1] = 32'h0000_0040;
    pcs[2] = 32'h7FFF_FFF0; pcs[3] = 32'hFFFF_FFFC;
    rst = 1'b1; vec_mode = 1'b0; dec_pc = '0; ex_pc = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 epc reset", epc_q, 32'd0);
    chk("R1 cause reset", {31'd0, cause_q}, 32'd0);
    chk("R1 outputs low", {27'd0, redirect, wb_kill, flush_if, flush_id, flush_ex}, 32'd0);
    rst = 1'b0;
    exp_epc = 32'd0; exp_cause = 1'b0;
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int e = 0; e < 2; e++)
          for (int k = 0; k < 4; k++)
            run_case(m[0], d[0], e[0], pcs[k], pcs[(k + 1) % 4] ^ 32'h0000_0100);
    // R10: wrap of the resume address
    run_case(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC, 32'h0);
    chk("R10 wrap", epc_q, 32'h0000_0000);
    run_case(1'b1, 1'b0, 1'b1, 32'h0, 32'hFFFF_FFFC);
    chk("R10 wrap ovf", epc_q, 32'h0000_0000);
    // back-to-back: fault right after strobe ends is accepted again (R7)
    run_case(1'b0, 1'b1, 1'b0, 32'h0000_0200, 32'h0);
    @(negedge clk);
    chk("R9 idle after", {31'd0, redirect}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule